// File: doc/BRIEF.md
# Power-On Special Mode Controller

This controller decides once per power-on which operating mode a bus-transceiver companion chip runs in, then gates the chip's supervisory functions to match. A qualified test-pin level captured in the first clock after power-on reset is released can select a forced-evaluation mode or a development mode. Development mode can also be requested by software through a one-shot special-mode write while the controller is still in start-up. In development mode the watchdog is suppressed. The mode survives only while every mode-register write keeps the development bit set. Once development mode is left, a new power-on reset is the only way back.

Forced-evaluation mode blocks register access and disables the watchdog, interrupt monitoring, reset monitoring and reset lengthening. It holds both bus transceivers active and drives both inhibit outputs high, and the enable output copies the reset output. Every fail-safe path is masked except a main-supply under-voltage that lasts longer than a parameterised number of ticks. A shorter under-voltage only holds the reset output low until the supply recovers. No data stream passes through the block, so every pin is a plain level or strobe with no valid/ready handshake.

Top module: `boot_mode_ctrl`

## Requirements
- R1: While `por_n_i` is low, `mode_o` reads 2'b00 (normal), `startup_o` is 1, `rst_n_o` is 0 and `failsafe_o` is 0.
- R2: On the first clock edge after `por_n_i` rises, the test pins are captured. `test_force_i` high gives `mode_o` 2'b10 (forced). Otherwise `test_dev_i` high gives 2'b01 (development). Forced wins when both are high. The choice of forced mode never changes until the next power-on reset.
- R3: A special-mode write (`spec_wr_i`) with `spec_dev_i` set enters development mode one cycle later. This requires the controller to be in start-up, the write to be the first special-mode write since power-on, development mode not to have been left, and the mode not to be forced.
- R4: A special-mode write has no effect after `startup_done_i` has ended start-up, or after any earlier special-mode write.
- R5: In development mode, a mode write (`mode_wr_i`) with `mode_dev_i` clear returns `mode_o` to 2'b00 one cycle later. A mode write with it set keeps development mode.
- R6: After development mode has been left, no special-mode write can re-enter it before the next power-on reset.
- R7: In forced mode, `spi_block_o` is 1 and `wdog_en_o`, `irq_mon_en_o`, `rst_mon_en_o` and `rst_ext_en_o` are 0. Mode and special-mode writes leave the mode unchanged.
- R8: In forced mode, `can_act_o`, `lin_act_o`, `inh_o` and `sysinh_o` are 1 and `en_o` equals `rst_n_o`.
- R9: `rst_n_o` is 0 in the cycle after `uv_i` is seen high and 1 in the cycle after it is seen low, in every mode. The mode is unchanged by an under-voltage.
- R10: `failsafe_o` latches high two cycles after the `UV_LIMIT`-th `tick_i` pulse of one unbroken `uv_i` assertion. The latch holds until power-on reset. Dropping `uv_i` clears the tick count, so fewer than `UV_LIMIT` ticks per assertion never trip it.
- R11: The external fail-safe source `fs_src_i` drives `failsafe_o` directly outside forced mode and is ignored in forced mode.
- R12: Outside forced mode, `spi_block_o` is 0 and `irq_mon_en_o`, `rst_mon_en_o` and `rst_ext_en_o` are 1. `wdog_en_o` is 1 only in normal mode. `can_act_o` and `lin_act_o` are 0, and `inh_o`, `sysinh_o` and `en_o` follow `inh_sw_i`, `sysinh_sw_i` and `en_sw_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| test_dev_i | input | 1 | Qualified test-pin level requesting development mode |
| test_force_i | input | 1 | Qualified test-pin level requesting forced-evaluation mode |
| startup_done_i | input | 1 | Strobe ending the start-up state |
| spec_wr_i | input | 1 | Special-mode register write strobe |
| spec_dev_i | input | 1 | Development-enable bit of the special-mode write |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_dev_i | input | 1 | Development bit of the mode write |
| uv_i | input | 1 | Main-supply under-voltage flag |
| tick_i | input | 1 | Free-running timebase tick |
| fs_src_i | input | 1 | Other fail-safe request sources |
| en_sw_i | input | 1 | Software value of the enable output |
| inh_sw_i | input | 1 | Software value of the inhibit output |
| sysinh_sw_i | input | 1 | Software value of the system inhibit output |
| mode_o | output | 2 | 00 normal, 01 development, 10 forced |
| startup_o | output | 1 | Start-up state active |
| spi_block_o | output | 1 | Register access blocked |
| wdog_en_o | output | 1 | Watchdog enable |
| irq_mon_en_o | output | 1 | Interrupt monitoring enable |
| rst_mon_en_o | output | 1 | Reset monitoring enable |
| rst_ext_en_o | output | 1 | Reset lengthening enable |
| can_act_o | output | 1 | CAN transceiver forced active |
| lin_act_o | output | 1 | LIN transceiver forced active |
| inh_o | output | 1 | Inhibit output |
| sysinh_o | output | 1 | System inhibit output |
| rst_n_o | output | 1 | Reset output, active low |
| en_o | output | 1 | Enable output |
| failsafe_o | output | 1 | Fail-safe request |

## Verification
The assertions check properties on every cycle. The forced choice stays fixed once captured. Development mode never reappears after a lockout, and a clearing mode write always exits it. The reset output tracks the under-voltage flag with one cycle of delay, and the fail-safe latch never falls. The output gating for forced mode is checked continuously as well. The bench scenarios are the only place that can show the entry rules as a whole: the capture priority across all test-pin combinations, the one-shot and start-up limits on the special-mode write, and the exact tick count at which the under-voltage escape trips.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_DEV    = 2'b01,
    MODE_FORCE  = 2'b10
  } mode_e;
endpackage

// File: rtl/bm_select.sv
module bm_select
  import boot_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  por_n_i,
  input  logic  test_dev_i,
  input  logic  test_force_i,
  input  logic  startup_done_i,
  input  logic  spec_wr_i,
  input  logic  spec_dev_i,
  input  logic  mode_wr_i,
  input  logic  mode_dev_i,
  output mode_e mode_o,
  output logic  startup_o
);
  logic sampled_q, force_q, dev_q, lock_q, startup_q, perm_q;
  logic spec_enter, dev_leave;

  assign spec_enter = sampled_q && !force_q && spec_wr_i && spec_dev_i &&
                      perm_q && startup_q && !lock_q && !dev_q;
  assign dev_leave  = sampled_q && dev_q && mode_wr_i && !mode_dev_i;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      sampled_q <= 1'b0;
      force_q   <= 1'b0;
      dev_q     <= 1'b0;
      lock_q    <= 1'b0;
      startup_q <= 1'b1;
      perm_q    <= 1'b1;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      force_q   <= test_force_i;
      dev_q     <= test_dev_i && !test_force_i;
    end else begin
      if (startup_q && startup_done_i) begin
        startup_q <= 1'b0;
        perm_q    <= 1'b0;
      end
      if (spec_wr_i) perm_q <= 1'b0;
      if (spec_enter) begin
        dev_q <= 1'b1;
      end else if (dev_leave) begin
        dev_q  <= 1'b0;
        lock_q <= 1'b1;
      end
    end
  end

  assign mode_o    = force_q ? MODE_FORCE : (dev_q ? MODE_DEV : MODE_NORMAL);
  assign startup_o = startup_q;

  // R2
  force_fixed_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (sampled_q && $past(sampled_q)) |-> $stable(force_q));
  // R5
  dev_exit_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (dev_q && sampled_q && mode_wr_i && !mode_dev_i) |=> !dev_q);
  // R6
  no_reentry_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (lock_q && !dev_q) |=> !dev_q);
  // R4
  late_spec_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (sampled_q && !startup_q && !dev_q) |=> !dev_q);
endmodule

// File: rtl/bm_uv_timer.sv
module bm_uv_timer #(
  parameter int UV_LIMIT = 8
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic uv_i,
  input  logic tick_i,
  output logic rst_n_o,
  output logic expired_o
);
  localparam int CW = $clog2(UV_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(UV_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          exp_q, rst_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= !uv_i;
      if (!uv_i)                        cnt_q <= '0;
      else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIMIT) exp_q <= 1'b1;
    end
  end

  assign rst_n_o   = rst_q;
  assign expired_o = exp_q;

  // R10
  fs_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    exp_q |=> exp_q);
  // R10
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !uv_i |=> (cnt_q == '0));
  // R9
  rst_follow_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    uv_i |=> !rst_n_o);
endmodule

// File: rtl/bm_gate.sv
module bm_gate
  import boot_mode_pkg::*;
(
  input  mode_e mode_i,
  input  logic  rst_n_i,
  input  logic  expired_i,
  input  logic  fs_src_i,
  input  logic  en_sw_i,
  input  logic  inh_sw_i,
  input  logic  sysinh_sw_i,
  output logic  spi_block_o,
  output logic  wdog_en_o,
  output logic  irq_mon_en_o,
  output logic  rst_mon_en_o,
  output logic  rst_ext_en_o,
  output logic  can_act_o,
  output logic  lin_act_o,
  output logic  inh_o,
  output logic  sysinh_o,
  output logic  en_o,
  output logic  failsafe_o
);
  logic frc;
  assign frc = (mode_i == MODE_FORCE);

  always_comb begin
    spi_block_o  = frc;
    wdog_en_o    = (mode_i == MODE_NORMAL);
    irq_mon_en_o = !frc;
    rst_mon_en_o = !frc;
    rst_ext_en_o = !frc;
    can_act_o    = frc;
    lin_act_o    = frc;
    inh_o        = frc ? 1'b1 : inh_sw_i;
    sysinh_o     = frc ? 1'b1 : sysinh_sw_i;
    en_o         = frc ? rst_n_i : en_sw_i;
    failsafe_o   = expired_i || (fs_src_i && !frc);
  end
endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
  import boot_mode_pkg::*;
#(
  parameter int UV_LIMIT = 8
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       test_dev_i,
  input  logic       test_force_i,
  input  logic       startup_done_i,
  input  logic       spec_wr_i,
  input  logic       spec_dev_i,
  input  logic       mode_wr_i,
  input  logic       mode_dev_i,
  input  logic       uv_i,
  input  logic       tick_i,
  input  logic       fs_src_i,
  input  logic       en_sw_i,
  input  logic       inh_sw_i,
  input  logic       sysinh_sw_i,
  output logic [1:0] mode_o,
  output logic       startup_o,
  output logic       spi_block_o,
  output logic       wdog_en_o,
  output logic       irq_mon_en_o,
  output logic       rst_mon_en_o,
  output logic       rst_ext_en_o,
  output logic       can_act_o,
  output logic       lin_act_o,
  output logic       inh_o,
  output logic       sysinh_o,
  output logic       rst_n_o,
  output logic       en_o,
  output logic       failsafe_o
);
  mode_e mode;
  logic  expired, rst_n;

  bm_select u_select (
    .clk_i, .por_n_i, .test_dev_i, .test_force_i, .startup_done_i,
    .spec_wr_i, .spec_dev_i, .mode_wr_i, .mode_dev_i,
    .mode_o(mode), .startup_o
  );

  bm_uv_timer #(.UV_LIMIT(UV_LIMIT)) u_uv (
    .clk_i, .por_n_i, .uv_i, .tick_i, .rst_n_o(rst_n), .expired_o(expired)
  );

  bm_gate u_gate (
    .mode_i(mode), .rst_n_i(rst_n), .expired_i(expired), .fs_src_i,
    .en_sw_i, .inh_sw_i, .sysinh_sw_i,
    .spi_block_o, .wdog_en_o, .irq_mon_en_o, .rst_mon_en_o, .rst_ext_en_o,
    .can_act_o, .lin_act_o, .inh_o, .sysinh_o, .en_o, .failsafe_o
  );

  assign mode_o  = mode;
  assign rst_n_o = rst_n;

  // R7
  force_gate_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (mode_o == 2'b10) |-> (spi_block_o && !wdog_en_o && !irq_mon_en_o &&
                           !rst_mon_en_o && !rst_ext_en_o));
  // R8
  force_drive_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (mode_o == 2'b10) |-> (can_act_o && lin_act_o && inh_o && sysinh_o &&
                           en_o == rst_n_o));
  // R11
  force_fs_mask_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (mode_o == 2'b10 && failsafe_o) |-> expired);
endmodule

// File: tb/test_boot_mode_ctrl.sv
module test_boot_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int UVL = 5;

  logic clk = 1'b0;
  logic por_n, tdev, tfrc, sdone, swr, sdev, mwr, mdev, uv, tick, fss, ensw, inhsw, sinhsw;
  logic [1:0] mode;
  logic startup, spib, wden, irqen, rmon, rext, cana, lina, inh, sinh, rstn, en, fs;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_mode_ctrl #(.UV_LIMIT(UVL)) i_boot_mode_ctrl (
    .clk_i(clk), .por_n_i(por_n), .test_dev_i(tdev), .test_force_i(tfrc),
    .startup_done_i(sdone), .spec_wr_i(swr), .spec_dev_i(sdev),
    .mode_wr_i(mwr), .mode_dev_i(mdev), .uv_i(uv), .tick_i(tick),
    .fs_src_i(fss), .en_sw_i(ensw), .inh_sw_i(inhsw), .sysinh_sw_i(sinhsw),
    .mode_o(mode), .startup_o(startup), .spi_block_o(spib), .wdog_en_o(wden),
    .irq_mon_en_o(irqen), .rst_mon_en_o(rmon), .rst_ext_en_o(rext),
    .can_act_o(cana), .lin_act_o(lina), .inh_o(inh), .sysinh_o(sinh),
    .rst_n_o(rstn), .en_o(en), .failsafe_o(fs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic por(input logic d, input logic f);
    @(negedge clk);
    por_n = 1'b0; tdev = d; tfrc = f;
    {sdone, swr, sdev, mwr, mdev, uv, tick, fss} = '0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    tdev = 1'b0; tfrc = 1'b0;
  endtask

  task automatic spec(input logic b);
    swr = 1'b1; sdev = b; @(negedge clk); swr = 1'b0; sdev = 1'b0;
  endtask

  task automatic mwrite(input logic b);
    mwr = 1'b1; mdev = b; @(negedge clk); mwr = 1'b0; mdev = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; {tdev, tfrc, sdone, swr, sdev, mwr, mdev, uv, tick, fss} = '0;
    ensw = 1'b0; inhsw = 1'b0; sinhsw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 startup", startup, 1);
    chk("R1 rst_n", rstn, 0);
    chk("R1 failsafe", fs, 0);

    // sweep: test-pin combinations x software entry scenarios
    for (int tp = 0; tp < 4; tp++) begin
      for (int sc = 0; sc < 4; sc++) begin
        logic f, dp, d;
        int e;
        f = tp[1]; dp = tp[0] & ~f;
        por(tp[0], tp[1]);
        chk("R2 capture", mode, f ? 2 : (dp ? 1 : 0));
        case (sc)
          0: begin spec(1'b1); d = ~f; end
          1: begin sdone = 1'b1; @(negedge clk); sdone = 1'b0; spec(1'b1); d = dp; end
          2: begin spec(1'b0); spec(1'b1); d = dp; end
          default: d = dp;
        endcase
        e = f ? 2 : (d ? 1 : 0);
        chk("R3 R4 entry", mode, e);
        chk("R7 R12 spi_block", spib, f);
        chk("R7 R12 wdog_en", wden, e == 0);
        chk("R7 R12 irq_mon", irqen, !f);
        chk("R7 R12 rst_ext", rext, !f);
        mwrite(1'b1);
        chk("R5 stay", mode, e);
        mwrite(1'b0);
        chk("R5 R7 exit", mode, f ? 2 : 0);
        spec(1'b1);
        chk("R6 reentry", mode, f ? 2 : ((sc == 3 && !dp) ? 1 : 0));
        inhsw = 1'b0; sinhsw = 1'b0; ensw = 1'b0;
        #1;
        chk("R8 R12 can_act", cana, f);
        chk("R8 R12 lin_act", lina, f);
        chk("R8 R12 inh", inh, f);
        chk("R8 R12 sysinh", sinh, f);
        chk("R8 R12 en", en, f ? rstn : 0);
        inhsw = 1'b1; sinhsw = 1'b1; ensw = 1'b1;
        #1;
        chk("R12 inh follow", inh, 1);
        chk("R12 en follow", en, 1);
      end
    end

    // under-voltage behaviour in normal and forced mode
    for (int f = 0; f < 2; f++) begin
      por(1'b0, f[0]);
      ensw = 1'b1;
      fss = 1'b1; #1;
      chk("R11 fs_src", fs, f == 0);
      fss = 1'b0;
      uv = 1'b1; @(negedge clk);
      chk("R9 rst low", rstn, 0);
      chk("R8 R12 en", en, f ? 0 : 1);
      ticks(UVL - 1);
      chk("R10 short uv", fs, 0);
      chk("R9 mode kept", mode, f ? 2 : 0);
      uv = 1'b0; @(negedge clk);
      chk("R9 rst high", rstn, 1);
      uv = 1'b1;
      ticks(UVL - 1);
      chk("R10 count cleared", fs, 0);
      ticks(1);
      @(negedge clk);
      chk("R10 trip", fs, 1);
      uv = 1'b0; @(negedge clk);
      chk("R10 latched", fs, 1);
      chk("R9 mode after", mode, f ? 2 : 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule